// File: doc/BRIEF.md
# Polled Serial Receiver Register Interface

This block is the register-side front end of a character terminal receiver. An external deserializer hands it one byte at a time on a single-cycle valid strobe. The block keeps the newest character and a done flag. When interrupts are enabled, it raises a level interrupt request. Software reaches the block over a simple single-cycle bus with read, write and byte-enable strobes. Address bit 1 picks one of two 16-bit words: a control/status word or the received-data buffer.

A static mode input picks the character width. In 7-bit mode the top bit of each incoming byte is forced to zero before it is stored; in 8-bit mode the byte is stored whole. Reading the buffer has a side effect: it acknowledges the character by clearing done and dropping the request. Enabling interrupts while a character is already waiting raises the request at once.

Top module: `serial_rx_regs`

## Requirements
- R1: `bus_addr1_i` selects the word. With 0, a read returns the control/status word; with 1, it returns the buffer. Read data is valid in the same cycle as `bus_rd_i` and is zero when no read is active.
- R2: A control/status read returns done in bit 7 and interrupt enable in bit 6. Every other bit reads as zero.
- R3: A control/status write with `bus_be_i[0]` set loads interrupt enable from write-data bit 6 at the next edge. A write with `bus_be_i[0]` clear changes nothing. Done is never written from the bus.
- R4: A control/status write with bit 6 clear leaves the interrupt request low after the edge.
- R5: A control/status write with bit 6 set while done is 1 drives the interrupt request high after the edge.
- R6: A buffer read returns the stored character in bits 7:0, with bits 15:8 zero. The edge that ends the read clears done and the interrupt request.
- R7: Writes to the buffer address change neither the buffer nor the flags.
- R8: On `rx_valid_i`, the byte is stored with bit 7 forced to 0 when `mode8_i` is 0, and kept as-is when `mode8_i` is 1. Done is set. The request is raised if interrupt enable, including an enable written in the same cycle, is 1. The request is only ever high while done and enable are both 1.
- R9: A character that arrives while done is still set overwrites the buffer. No overrun indication exists.
- R10: When a buffer read and `rx_valid_i` fall in the same cycle, the read returns the old character. The new character is stored, done stays 1, and the request follows interrupt enable.
- R11: Asynchronous reset clears the buffer, done, interrupt enable and the interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr1_i | input | 1 | Address bit 1: 0 control/status, 1 buffer |
| bus_be_i | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data (combinational) |
| rx_valid_i | input | 1 | Character valid strobe from the deserializer |
| rx_data_i | input | 8 | Incoming character |
| mode8_i | input | 1 | 1: 8-bit characters, 0: 7-bit characters |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two functions can fall in the same edge: a software acknowledge, which is a buffer read, and a new character arrival. The bench drives the read strobe and `rx_valid_i` in the same cycle while interrupts are enabled. It checks that the data read is the old character. It then reads the control/status word and the buffer again, expecting done still set, the request still high and the new character stored. A second collision pairs an interrupt-enable write with an arrival, and the request must follow the newly written enable.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int REG_W    = 16;
  localparam int CHAR_W   = 8;
  localparam int BE_W     = REG_W / 8;
  localparam int DONE_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int PAD_W    = REG_W - CHAR_W;

  typedef struct packed {
    logic csr_rd;
    logic csr_wr;   // low byte enabled
    logic buf_rd;
  } srx_acc_t;
endpackage

// File: rtl/srx_decode.sv
module srx_decode
  import srx_pkg::*;
(
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic            addr1_i,
  input  logic [BE_W-1:0] be_i,
  output srx_acc_t        acc_o
);
  logic unused_be_hi;
  assign unused_be_hi = ^be_i[BE_W-1:1];

  always_comb begin
    acc_o        = '0;
    acc_o.csr_rd = rd_i & ~addr1_i;
    acc_o.csr_wr = wr_i & ~addr1_i & be_i[0];
    acc_o.buf_rd = rd_i & addr1_i;
    // buffer writes decode to nothing
  end
endmodule

// File: rtl/srx_char_buf.sv
module srx_char_buf
  import srx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              mode8_i,
  output logic [CHAR_W-1:0] char_o
);
  logic [CHAR_W-1:0] masked;

  for (genvar b = 0; b < CHAR_W; b++) begin : g_mask
    if (b < CHAR_W - 1) begin : g_pass
      assign masked[b] = rx_data_i[b];
    end else begin : g_top
      assign masked[b] = rx_data_i[b] & mode8_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         char_o <= '0;
    else if (rx_valid_i) char_o <= masked;
  end
endmodule

// File: rtl/srx_flags.sv
module srx_flags
  import srx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  srx_acc_t acc_i,
  input  logic     wr_ie_i,
  input  logic     rx_valid_i,
  output logic     done_o,
  output logic     ie_o,
  output logic     irq_o
);
  logic done_d, ie_d, irq_d;

  always_comb begin
    ie_d   = acc_i.csr_wr ? wr_ie_i : ie_o;
    done_d = done_o;
    irq_d  = irq_o;
    if (acc_i.csr_wr) begin
      if (!wr_ie_i)                  irq_d = 1'b0;
      else if (done_o && !ie_o)      irq_d = 1'b1;
    end
    if (acc_i.buf_rd) begin
      done_d = 1'b0;
      irq_d  = 1'b0;
    end
    // arrival wins over a same-cycle acknowledge
    if (rx_valid_i) begin
      done_d = 1'b1;
      if (ie_d) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      ie_o   <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      done_o <= done_d;
      ie_o   <= ie_d;
      irq_o  <= irq_d;
    end
  end
endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs
  import srx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic              bus_addr1_i,
  input  logic [BE_W-1:0]   bus_be_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              mode8_i,
  output logic              irq_o
);
  srx_acc_t          acc;
  logic              done_q, ie_q;
  logic [CHAR_W-1:0] char_q;
  logic [REG_W-1:0]  csr_word;
  logic              unused_wdata;

  assign unused_wdata = ^{bus_wdata_i[REG_W-1:IE_BIT+1], bus_wdata_i[IE_BIT-1:0]};

  srx_decode i_decode (
    .rd_i    (bus_rd_i),
    .wr_i    (bus_wr_i),
    .addr1_i (bus_addr1_i),
    .be_i    (bus_be_i),
    .acc_o   (acc)
  );

  srx_char_buf i_char_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .mode8_i    (mode8_i),
    .char_o     (char_q)
  );

  srx_flags i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .wr_ie_i    (bus_wdata_i[IE_BIT]),
    .rx_valid_i (rx_valid_i),
    .done_o     (done_q),
    .ie_o       (ie_q),
    .irq_o      (irq_o)
  );

  always_comb begin
    csr_word           = '0;
    csr_word[DONE_BIT] = done_q;
    csr_word[IE_BIT]   = ie_q;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (acc.csr_rd)      bus_rdata_o = csr_word;
    else if (acc.buf_rd) bus_rdata_o = {{PAD_W{1'b0}}, char_q};
  end
endmodule

// File: rtl/srx_checker.sv
module srx_checker
  import srx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_rd_i,
  input logic              bus_wr_i,
  input logic              bus_addr1_i,
  input logic [BE_W-1:0]   bus_be_i,
  input logic [REG_W-1:0]  bus_wdata_i,
  input logic              rx_valid_i,
  input logic              mode8_i,
  input logic              irq_o,
  input logic              done_q,
  input logic              ie_q,
  input logic [CHAR_W-1:0] char_q
);
  assert_hi_byte_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !bus_be_i[0]) |=> $stable(ie_q));

  assert_ie_clear_drops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !bus_addr1_i && bus_be_i[0] && !bus_wdata_i[IE_BIT]) |=> !irq_o);

  assert_ie_set_raises_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !bus_addr1_i && bus_be_i[0] && bus_wdata_i[IE_BIT] && done_q) |=> irq_o);

  assert_buf_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr1_i && !rx_valid_i) |=> (!done_q && !irq_o));

  assert_rx_sets_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> done_q);

  assert_seven_bit_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !mode8_i) |=> !char_q[CHAR_W-1]);

  assert_irq_needs_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (done_q && ie_q));
endmodule

bind serial_rx_regs srx_checker i_srx_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_rd_i    (bus_rd_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr1_i (bus_addr1_i),
  .bus_be_i    (bus_be_i),
  .bus_wdata_i (bus_wdata_i),
  .rx_valid_i  (rx_valid_i),
  .mode8_i     (mode8_i),
  .irq_o       (irq_o),
  .done_q      (done_q),
  .ie_q        (ie_q),
  .char_q      (char_q)
);

// File: tb/test_serial_rx_regs.sv
`timescale 1ns/1ps
module test_serial_rx_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_rd_i = 1'b0, bus_wr_i = 1'b0, bus_addr1_i = 1'b0;
  logic [1:0]  bus_be_i = 2'b00;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        mode8_i = 1'b1;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] rd_val;

  always #2.5 clk_i = ~clk_i;

  serial_rx_regs i_serial_rx_regs (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic a1, output logic [15:0] v);
    @(negedge clk_i);
    bus_rd_i = 1'b1; bus_addr1_i = a1;
    #1 v = bus_rdata_o;
    @(negedge clk_i);
    bus_rd_i = 1'b0;
  endtask

  task automatic bus_write(input logic a1, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk_i);
    bus_wr_i = 1'b1; bus_addr1_i = a1; bus_be_i = be; bus_wdata_i = d;
    @(negedge clk_i);
    bus_wr_i = 1'b0; bus_be_i = 2'b00;
  endtask

  task automatic rx_char(input logic [7:0] c);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = c;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R11 reset state, R1 idle bus reads zero
    chk("R11 irq", {15'd0, irq_o}, 16'h0);
    chk("R1 idle rdata", bus_rdata_o, 16'h0);
    bus_read(1'b0, rd_val); chk("R11 csr", rd_val, 16'h0000);
    bus_read(1'b1, rd_val); chk("R11 buffer", rd_val, 16'h0000);

    // R3: high-byte-only write ignored; done not writable; R2 other bits zero
    bus_write(1'b0, 2'b10, 16'hFFFF);
    bus_read(1'b0, rd_val); chk("R3 high byte ignored", rd_val, 16'h0000);
    bus_write(1'b0, 2'b11, 16'hFFFF);
    bus_read(1'b0, rd_val); chk("R2 R3 ie only", rd_val, 16'h0040);
    chk("R4 no irq without done", {15'd0, irq_o}, 16'h0);
    bus_write(1'b0, 2'b01, 16'h0000);

    // R8 sweep: both modes, ie on/off, every character value
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 2; e++) begin
        mode8_i = m[0];
        bus_write(1'b0, 2'b01, e[0] ? 16'h0040 : 16'h0000);
        for (int c = 0; c < 256; c++) begin
          logic [7:0] exp_c;
          exp_c = m[0] ? c[7:0] : {1'b0, c[6:0]};
          rx_char(c[7:0]);
          chk("R8 irq after char", {15'd0, irq_o}, {15'd0, e[0]});
          bus_read(1'b0, rd_val);
          chk("R2 R8 csr after char", rd_val, {8'h00, 1'b1, e[0], 6'h00});
          bus_read(1'b1, rd_val);
          chk("R6 R8 buffer value", rd_val, {8'h00, exp_c});
          chk("R6 irq cleared", {15'd0, irq_o}, 16'h0);
          bus_read(1'b0, rd_val);
          chk("R6 done cleared", rd_val, {8'h00, 1'b0, e[0], 6'h00});
        end
      end
    end

    // R5 / R4: late enable raises, disable drops
    mode8_i = 1'b1;
    bus_write(1'b0, 2'b01, 16'h0000);
    rx_char(8'hA5);
    chk("R8 no irq with ie clear", {15'd0, irq_o}, 16'h0);
    bus_write(1'b0, 2'b01, 16'h0040);
    chk("R5 enable raises", {15'd0, irq_o}, 16'h1);
    bus_write(1'b0, 2'b01, 16'h0000);
    chk("R4 disable drops", {15'd0, irq_o}, 16'h0);
    bus_read(1'b0, rd_val); chk("R4 done kept", rd_val, 16'h0080);

    // R7: buffer writes ignored
    bus_write(1'b1, 2'b11, 16'h005A);
    bus_read(1'b0, rd_val); chk("R7 flags unchanged", rd_val, 16'h0080);
    bus_read(1'b1, rd_val); chk("R7 buffer unchanged", rd_val, 16'h00A5);

    // R9 overrun overwrites
    rx_char(8'h11);
    rx_char(8'h22);
    bus_read(1'b0, rd_val); chk("R9 done only", rd_val, 16'h0080);
    bus_read(1'b1, rd_val); chk("R9 newest kept", rd_val, 16'h0022);

    // R10 acknowledge and arrival in one cycle
    bus_write(1'b0, 2'b01, 16'h0040);
    rx_char(8'h3C);
    @(negedge clk_i);
    bus_rd_i = 1'b1; bus_addr1_i = 1'b1; rx_valid_i = 1'b1; rx_data_i = 8'hC3;
    #1 chk("R10 old char read", bus_rdata_o, 16'h003C);
    @(negedge clk_i);
    bus_rd_i = 1'b0; rx_valid_i = 1'b0;
    chk("R10 irq kept", {15'd0, irq_o}, 16'h1);
    bus_read(1'b0, rd_val); chk("R10 done kept", rd_val, 16'h00C0);
    bus_read(1'b1, rd_val); chk("R10 new char", rd_val, 16'h00C3);

    // R8 enable written in the same cycle as an arrival
    bus_write(1'b0, 2'b01, 16'h0000);
    @(negedge clk_i);
    bus_wr_i = 1'b1; bus_addr1_i = 1'b0; bus_be_i = 2'b01; bus_wdata_i = 16'h0040;
    rx_valid_i = 1'b1; rx_data_i = 8'h7E;
    @(negedge clk_i);
    bus_wr_i = 1'b0; bus_be_i = 2'b00; rx_valid_i = 1'b0;
    chk("R8 same-cycle enable", {15'd0, irq_o}, 16'h1);

    // R11 reset mid-run
    rst_ni = 1'b0;
    #1 chk("R11 irq async clear", {15'd0, irq_o}, 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    bus_read(1'b0, rd_val); chk("R11 csr after reset", rd_val, 16'h0000);
    bus_read(1'b1, rd_val); chk("R11 buffer after reset", rd_val, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule